// File: doc/BRIEF.md
# Link-Layer Receive Error Classifier

This block sits in the receive half of a PCIe data link layer, just after the physical layer hands over packet boundaries and CRC results. For every received TLP it decides one of six verdicts: accepted, duplicate, nullified, bad LCRC, bad sequence, or dropped because the physical layer flagged it. For every DLLP it decides between accepted and discarded. It also gathers link-level events into a seven-bit cause vector and raises a correctable or an uncorrectable error pulse. The verdicts and the error pulses come out one clock after the input strobes.

The block owns the expected receive sequence counter. That counter advances only when a good TLP arrives in sequence. A TLP whose sequence number lags the counter by at most half the number space is a replayed copy, and it is dropped without an error. A TLP that ended with EDB and carries an inverted LCRC was cancelled by its sender, and it is dropped without an error. When the physical layer has already reported a fault on a packet, the link-layer checks for that packet stay silent, so one fault is never reported twice. CRC generation and replay storage belong to other blocks.

The TLP verdict is an enumerated code. The RTL decodes it with a unique case, and its names are used throughout: TV_NONE, TV_GOOD, TV_DUP, TV_NULL, TV_BAD_LCRC, TV_BAD_SEQ, TV_PHY. The only sequential state is the expected sequence counter. It has one transition, "advance", taken on TV_GOOD, and it holds on every other verdict.

Top module: `dll_rx_errclass`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `next_rcv_seq` is 0 and every output strobe, `tlp_verdict` and `err_cause` are 0.
- R2: A TLP end with no physical fault, no EDB, a good LCRC and `tlp_seq == next_rcv_seq` gives `tlp_verdict`=1 (good) and `tlp_accept`. `next_rcv_seq` then increments modulo 2^SEQ_W, so 4095 wraps to 0.
- R3: A TLP end with no physical fault, no EDB and a bad LCRC gives `tlp_verdict`=4. It is discarded, sets `err_cause[0]` and does not move `next_rcv_seq`. A TLP end with EDB whose inverted LCRC does not match gives the same result.
- R4: A TLP end with EDB whose inverted LCRC matches, and no physical fault, gives `tlp_verdict`=3 (nullified). It is discarded with no cause bit set, and `next_rcv_seq` is unchanged.
- R5: A good-LCRC TLP whose sequence number lags `next_rcv_seq` by 1 to 2048 (modulo 4096) gives `tlp_verdict`=2 (duplicate). It is discarded silently, and `next_rcv_seq` is unchanged.
- R6: A good-LCRC TLP whose sequence number is neither equal nor a duplicate gives `tlp_verdict`=5. It is discarded, sets `err_cause[0]`, and `next_rcv_seq` is unchanged.
- R7: A DLLP end with no physical fault gives `dllp_accept` when `dllp_crc_ok` is high. Otherwise it gives `dllp_discard` and sets `err_cause[1]`.
- R8: `replay_timeout` sets `err_cause[2]` and `replay_num_roll` sets `err_cause[3]`. Both are correctable.
- R9: `phy_link_err` (a link or framing fault) sets `err_cause[4]`, which is correctable.
- R10: `dl_proto_err` sets `err_cause[5]` and `surprise_down` sets `err_cause[6]`. Both are uncorrectable.
- R11: A packet ending with its physical-fault flag set is discarded (TLP verdict 6) with no link-layer cause bit and no sequence advance, whatever its CRC and sequence number.
- R12: All outputs are registered one cycle after their inputs. Several cause bits may be set in the same cycle. `cor_err` is the OR of `err_cause[4:0]` and `uncor_err` is the OR of `err_cause[6:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tlp_end | input | 1 | A TLP ends this cycle |
| tlp_edb | input | 1 | That TLP ended with EDB |
| tlp_lcrc_ok | input | 1 | Received LCRC equals the computed LCRC |
| tlp_lcrc_inv_ok | input | 1 | Received LCRC equals the inverted computed LCRC |
| tlp_seq | input | SEQ_W | Sequence number of the TLP |
| tlp_phy_err | input | 1 | Physical layer flagged this TLP |
| dllp_end | input | 1 | A DLLP ends this cycle |
| dllp_crc_ok | input | 1 | DLLP CRC matched |
| dllp_phy_err | input | 1 | Physical layer flagged this DLLP |
| phy_link_err | input | 1 | Link or framing fault event |
| replay_timeout | input | 1 | Replay timer expired |
| replay_num_roll | input | 1 | Replay count rolled over |
| dl_proto_err | input | 1 | Link protocol violation |
| surprise_down | input | 1 | Unexpected link loss |
| tlp_accept | output | 1 | TLP forwarded |
| tlp_discard | output | 1 | TLP dropped |
| tlp_verdict | output | 3 | TLP verdict code |
| dllp_accept | output | 1 | DLLP forwarded |
| dllp_discard | output | 1 | DLLP dropped |
| err_cause | output | 7 | Per-cause error flags |
| cor_err | output | 1 | Correctable error pulse |
| uncor_err | output | 1 | Uncorrectable error pulse |
| next_rcv_seq | output | SEQ_W | Expected next sequence number |

## Verification
The bench builds the block with its default SEQ_W of 12, so the duplicate window spans exactly 2048 numbers. A chain of good TLPs walks the counter through its full 4096-value ring and exercises the 4095-to-0 wrap. With the counter at 0, directed packets probe lags of 1, 2048 and 2049, which checks both edges of the duplicate window against the bad-sequence case. The random traffic mixes EDB, physical flags and link events in the same cycles.

// File: rtl/dllrx_pkg.sv
package dllrx_pkg;

    typedef enum logic [2:0] {
        TV_NONE     = 3'd0,
        TV_GOOD     = 3'd1,
        TV_DUP      = 3'd2,
        TV_NULL     = 3'd3,
        TV_BAD_LCRC = 3'd4,
        TV_BAD_SEQ  = 3'd5,
        TV_PHY      = 3'd6
    } tlp_verdict_e;

    localparam int CAUSE_W       = 7;
    localparam int C_BAD_TLP     = 0;
    localparam int C_BAD_DLLP    = 1;
    localparam int C_REPLAY_TO   = 2;
    localparam int C_REPLAY_ROLL = 3;
    localparam int C_PHY_LINK    = 4;
    localparam int C_DL_PROTO    = 5;
    localparam int C_SURPRISE    = 6;
    localparam int COR_MSB       = 4;

endpackage

// File: rtl/dllrx_seq_track.sv
module dllrx_seq_track #(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [SEQ_W-1:0] rx_seq,
    output logic [SEQ_W-1:0] expected,
    output logic             in_seq,
    output logic             in_dup
);
    localparam logic [SEQ_W-1:0] HALF = SEQ_W'(1) << (SEQ_W - 1);
    localparam logic [SEQ_W-1:0] ONE  = SEQ_W'(1);

    logic [SEQ_W-1:0] lag;

    // distance the received number trails the expected one, modulo 2^SEQ_W
    always_comb begin
        lag    = expected - rx_seq;
        in_seq = (lag == '0);
        in_dup = (lag != '0) && (lag <= HALF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            expected <= '0;
        else if (advance)
            expected <= expected + ONE;
    end

    a_r2_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(expected));

endmodule

// File: rtl/dllrx_tlp_class.sv
module dllrx_tlp_class
    import dllrx_pkg::*;
(
    input  logic         tlp_end,
    input  logic         tlp_edb,
    input  logic         tlp_lcrc_ok,
    input  logic         tlp_lcrc_inv_ok,
    input  logic         tlp_phy_err,
    input  logic         in_seq,
    input  logic         in_dup,
    output tlp_verdict_e verdict
);
    // priority: physical fault, then end-of-packet kind, then CRC, then sequence
    always_comb begin
        if (!tlp_end)
            verdict = TV_NONE;
        else if (tlp_phy_err)
            verdict = TV_PHY;
        else if (tlp_edb)
            verdict = tlp_lcrc_inv_ok ? TV_NULL : TV_BAD_LCRC;
        else if (!tlp_lcrc_ok)
            verdict = TV_BAD_LCRC;
        else if (in_seq)
            verdict = TV_GOOD;
        else if (in_dup)
            verdict = TV_DUP;
        else
            verdict = TV_BAD_SEQ;
    end

    a_r11_phy_wins: assert final (!(tlp_end && tlp_phy_err) || verdict == TV_PHY);

endmodule

// File: rtl/dllrx_dllp_check.sv
module dllrx_dllp_check (
    input  logic dllp_end,
    input  logic dllp_crc_ok,
    input  logic dllp_phy_err,
    output logic accept,
    output logic discard,
    output logic bad
);
    always_comb begin
        accept  = dllp_end && !dllp_phy_err && dllp_crc_ok;
        bad     = dllp_end && !dllp_phy_err && !dllp_crc_ok;
        discard = dllp_end && (dllp_phy_err || !dllp_crc_ok);
    end

    a_r7_split: assert final (!(accept && discard));

endmodule

// File: rtl/dll_rx_errclass.sv
module dll_rx_errclass
    import dllrx_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tlp_end,
    input  logic             tlp_edb,
    input  logic             tlp_lcrc_ok,
    input  logic             tlp_lcrc_inv_ok,
    input  logic [SEQ_W-1:0] tlp_seq,
    input  logic             tlp_phy_err,
    input  logic             dllp_end,
    input  logic             dllp_crc_ok,
    input  logic             dllp_phy_err,
    input  logic             phy_link_err,
    input  logic             replay_timeout,
    input  logic             replay_num_roll,
    input  logic             dl_proto_err,
    input  logic             surprise_down,
    output logic             tlp_accept,
    output logic             tlp_discard,
    output logic [2:0]       tlp_verdict,
    output logic             dllp_accept,
    output logic             dllp_discard,
    output logic [6:0]       err_cause,
    output logic             cor_err,
    output logic             uncor_err,
    output logic [SEQ_W-1:0] next_rcv_seq
);
    tlp_verdict_e       verdict;
    logic               in_seq, in_dup;
    logic               t_acc, t_disc, t_bad;
    logic               d_acc, d_disc, d_bad;
    logic [CAUSE_W-1:0] cause_d;

    dllrx_seq_track #(.SEQ_W(SEQ_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (t_acc),
        .rx_seq   (tlp_seq),
        .expected (next_rcv_seq),
        .in_seq   (in_seq),
        .in_dup   (in_dup)
    );

    dllrx_tlp_class u_tlp (
        .tlp_end         (tlp_end),
        .tlp_edb         (tlp_edb),
        .tlp_lcrc_ok     (tlp_lcrc_ok),
        .tlp_lcrc_inv_ok (tlp_lcrc_inv_ok),
        .tlp_phy_err     (tlp_phy_err),
        .in_seq          (in_seq),
        .in_dup          (in_dup),
        .verdict         (verdict)
    );

    dllrx_dllp_check u_dllp (
        .dllp_end     (dllp_end),
        .dllp_crc_ok  (dllp_crc_ok),
        .dllp_phy_err (dllp_phy_err),
        .accept       (d_acc),
        .discard      (d_disc),
        .bad          (d_bad)
    );

    // verdict decode
    always_comb begin
        t_acc  = 1'b0;
        t_disc = 1'b0;
        t_bad  = 1'b0;
        unique case (verdict)
            TV_NONE:                ;
            TV_GOOD:                t_acc = 1'b1;
            TV_DUP, TV_NULL, TV_PHY: t_disc = 1'b1;
            TV_BAD_LCRC, TV_BAD_SEQ: begin
                t_disc = 1'b1;
                t_bad  = 1'b1;
            end
            default:                ;
        endcase
    end

    always_comb begin
        cause_d                = '0;
        cause_d[C_BAD_TLP]     = t_bad;
        cause_d[C_BAD_DLLP]    = d_bad;
        cause_d[C_REPLAY_TO]   = replay_timeout;
        cause_d[C_REPLAY_ROLL] = replay_num_roll;
        cause_d[C_PHY_LINK]    = phy_link_err;
        cause_d[C_DL_PROTO]    = dl_proto_err;
        cause_d[C_SURPRISE]    = surprise_down;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tlp_accept   <= 1'b0;
            tlp_discard  <= 1'b0;
            tlp_verdict  <= 3'd0;
            dllp_accept  <= 1'b0;
            dllp_discard <= 1'b0;
            err_cause    <= '0;
            cor_err      <= 1'b0;
            uncor_err    <= 1'b0;
        end else begin
            tlp_accept   <= t_acc;
            tlp_discard  <= t_disc;
            tlp_verdict  <= 3'(verdict);
            dllp_accept  <= d_acc;
            dllp_discard <= d_disc;
            err_cause    <= cause_d;
            cor_err      <= |cause_d[COR_MSB:0];
            uncor_err    <= |cause_d[CAUSE_W-1:COR_MSB+1];
        end
    end

    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        tlp_accept |-> next_rcv_seq == $past(next_rcv_seq) + SEQ_W'(1));
    a_r12_accept_or_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlp_accept, tlp_discard}));
    a_r4_null_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_end && !tlp_phy_err && tlp_edb && tlp_lcrc_inv_ok)
        |=> (tlp_discard && !err_cause[C_BAD_TLP] && $stable(next_rcv_seq)));
    a_r11_phy_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_end && tlp_phy_err) |=> (!tlp_accept && !err_cause[C_BAD_TLP]));
    a_r8_replay_cor: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_timeout || replay_num_roll) |=> cor_err);
    a_r10_fatal_uncor: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_proto_err || surprise_down) |=> uncor_err);

endmodule

// File: tb/dll_rx_errclass_bench.sv
module dll_rx_errclass_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tlp_end = 0, tlp_edb = 0, tlp_lcrc_ok = 0, tlp_lcrc_inv_ok = 0, tlp_phy_err = 0;
    logic [11:0] tlp_seq = '0;
    logic        dllp_end = 0, dllp_crc_ok = 0, dllp_phy_err = 0;
    logic        phy_link_err = 0, replay_timeout = 0, replay_num_roll = 0;
    logic        dl_proto_err = 0, surprise_down = 0;
    logic        tlp_accept, tlp_discard, dllp_accept, dllp_discard, cor_err, uncor_err;
    logic [2:0]  tlp_verdict;
    logic [6:0]  err_cause;
    logic [11:0] next_rcv_seq;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [11:0] exp_next = '0;

    always #5 clk = ~clk;

    dll_rx_errclass #(.SEQ_W(12)) u_dll_rx_errclass (
        .clk(clk), .rst_n(rst_n),
        .tlp_end(tlp_end), .tlp_edb(tlp_edb), .tlp_lcrc_ok(tlp_lcrc_ok),
        .tlp_lcrc_inv_ok(tlp_lcrc_inv_ok), .tlp_seq(tlp_seq), .tlp_phy_err(tlp_phy_err),
        .dllp_end(dllp_end), .dllp_crc_ok(dllp_crc_ok), .dllp_phy_err(dllp_phy_err),
        .phy_link_err(phy_link_err), .replay_timeout(replay_timeout),
        .replay_num_roll(replay_num_roll), .dl_proto_err(dl_proto_err),
        .surprise_down(surprise_down),
        .tlp_accept(tlp_accept), .tlp_discard(tlp_discard), .tlp_verdict(tlp_verdict),
        .dllp_accept(dllp_accept), .dllp_discard(dllp_discard), .err_cause(err_cause),
        .cor_err(cor_err), .uncor_err(uncor_err), .next_rcv_seq(next_rcv_seq)
    );

    function automatic logic [2:0] ref_verdict(bit te, bit edb, bit lok, bit iok,
                                               logic [11:0] sq, bit phy, logic [11:0] nxt);
        logic [11:0] lag;
        lag = nxt - sq;
        if (!te)        return 3'd0;
        if (phy)        return 3'd6;
        if (edb)        return iok ? 3'd3 : 3'd4;
        if (!lok)       return 3'd4;
        if (lag == 0)   return 3'd1;
        if (lag <= 12'd2048) return 3'd2;
        return 3'd5;
    endfunction

    function automatic string verdict_req(logic [2:0] v);
        case (v)
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R3";
            3'd5: return "R6";
            3'd6: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit te, bit edb, bit lok, bit iok, logic [11:0] sq, bit tphy,
                        bit de, bit dok, bit dphy, bit ple, bit rto, bit rrl, bit dpe, bit sd);
        logic [2:0]  v;
        logic [6:0]  cz;
        bit          bad;
        v   = ref_verdict(te, edb, lok, iok, sq, tphy, exp_next);
        bad = (v == 3'd4) || (v == 3'd5);
        cz  = {sd, dpe, ple, rrl, rto, (de && !dphy && !dok), bad};
        tlp_end = te; tlp_edb = edb; tlp_lcrc_ok = lok; tlp_lcrc_inv_ok = iok;
        tlp_seq = sq; tlp_phy_err = tphy;
        dllp_end = de; dllp_crc_ok = dok; dllp_phy_err = dphy;
        phy_link_err = ple; replay_timeout = rto; replay_num_roll = rrl;
        dl_proto_err = dpe; surprise_down = sd;
        if (v == 3'd1) exp_next = exp_next + 12'd1;
        @(posedge clk);
        @(negedge clk);
        chk(verdict_req(v), "verdict", 32'(tlp_verdict), 32'(v));
        chk(verdict_req(v), "tlp_accept", 32'(tlp_accept), 32'(v == 3'd1));
        chk(verdict_req(v), "tlp_discard", 32'(tlp_discard), 32'(v >= 3'd2));
        chk("R2", "next_rcv_seq", 32'(next_rcv_seq), 32'(exp_next));
        chk("R3", "cause bad tlp", 32'(err_cause[0]), 32'(cz[0]));
        chk("R7", "cause bad dllp", 32'(err_cause[1]), 32'(cz[1]));
        chk("R7", "dllp_accept", 32'(dllp_accept), 32'(de && !dphy && dok));
        chk("R7", "dllp_discard", 32'(dllp_discard), 32'(de && (dphy || !dok)));
        chk("R8", "cause replay", 32'(err_cause[3:2]), 32'(cz[3:2]));
        chk("R9", "cause phy link", 32'(err_cause[4]), 32'(cz[4]));
        chk("R10", "cause uncorrectable", 32'(err_cause[6:5]), 32'(cz[6:5]));
        chk("R12", "cor_err", 32'(cor_err), 32'(|cz[4:0]));
        chk("R12", "uncor_err", 32'(uncor_err), 32'(|cz[6:5]));
    endtask

    task automatic good_tlp(logic [11:0] sq);
        step(1, 0, 1, 0, sq, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "next_rcv_seq in reset", 32'(next_rcv_seq), 32'd0);
        chk("R1", "strobes in reset", 32'({tlp_accept, tlp_discard, dllp_accept, dllp_discard,
                                            cor_err, uncor_err}), 32'd0);
        chk("R1", "cause/verdict in reset", 32'({err_cause, tlp_verdict}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", 32'({next_rcv_seq, err_cause, tlp_verdict}), 32'd0);

        // directed corners at next=0
        step(1, 1, 0, 1, 12'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // R4 nullified
        step(1, 1, 1, 0, 12'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // R3/R4 EDB without inverted match
        step(1, 0, 0, 0, 12'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // R3 bad LCRC
        step(1, 0, 0, 0, 12'd5, 1, 1, 0, 1, 0, 0, 0, 0, 0);  // R11 phy suppresses both
        step(1, 0, 1, 0, 12'd2048, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R5 lag 2048
        step(1, 0, 1, 0, 12'd2047, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R6 lag 2049
        step(1, 0, 1, 0, 12'd4095, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R5 lag 1
        step(1, 0, 1, 0, 12'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0);    // R6 one ahead
        good_tlp(12'd0);                                        // R2
        step(0, 0, 0, 0, 12'd0, 0, 1, 0, 0, 1, 1, 1, 1, 1);    // R12 all causes together
        step(0, 0, 0, 0, 12'd0, 0, 1, 1, 0, 0, 0, 0, 0, 0);    // R7 good DLLP

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] sq;
            int unsigned pick;
            pick = $urandom % 4;
            if (pick < 2)       sq = exp_next;
            else if (pick == 2) sq = exp_next - 12'(1 + ($urandom % 2048));
            else                sq = exp_next + 12'(1 + ($urandom % 2047));
            step(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) != 0,
                 ($urandom % 2) == 0, sq, ($urandom % 16) == 0,
                 ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 16) == 0,
                 ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0,
                 ($urandom % 12) == 0, ($urandom % 12) == 0);
        end

        // R2: walk to the top of the ring and wrap
        while (exp_next != 12'd4095) good_tlp(exp_next);
        good_tlp(12'd4095);
        chk("R2", "wrap to zero", 32'(next_rcv_seq), 32'd0);
        step(1, 0, 1, 0, 12'd2048, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R5 after wrap
        step(0, 0, 0, 0, 12'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule